// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Sequencer

This block keeps an asynchronous DRAM alive. After reset it holds every strobe inactive for a power-up pause, then drives a warm-up burst of refresh cycles on its own authority. Once the burst is over it raises `init_done` and enters normal service. A free-running interval timer then adds one refresh obligation to a small backlog every interval. While the backlog is non-empty and the strobe generator is idle, the block asks the memory controller for the bus.

When the controller grants the bus, the block runs one refresh cycle. The `cbr_mode` input selects which kind, and it is sampled at the start of each cycle. In CAS-before-RAS mode the row address is ignored. In row-strobe-only mode the block places its own row counter on `row_addr`, with CAS held high.

All timing figures are given in nanoseconds. They are turned into whole clock cycles at elaboration from the clock frequency, rounding up.

Top module: `dram_refresh_seq`

## Requirements
- R1: While `rst_n` is low, `ras_n`, `cas_n` and `we_n` are 1; `ref_req`, `init_done` and `pend_overflow` are 0; `row_addr` is 0.
- R2: After reset is released, no strobe goes low during the first PAUSE clock cycles. The first strobe activity appears after clock edge PAUSE+1, counting the first edge after release as edge 1.
- R3: The warm-up burst runs exactly INIT_CYCLES refresh cycles whether `grant` is high or low, and `ref_req` stays 0 throughout. `init_done` rises RP cycles after `ras_n` returns high at the end of the last warm-up cycle, and then stays 1.
- R4: Once `init_done` is 1, one refresh obligation accrues every INTERVAL cycles. The first makes `ref_req` rise exactly INTERVAL cycles after `init_done` rises. With `grant` held high, exactly one refresh cycle runs per interval.
- R5: `ref_req` is 1 when the backlog is non-empty and no refresh cycle is running. If `grant` is 1 while `ref_req` is 1, a refresh cycle starts at the next clock edge and `ref_req` drops to 0.
- R6: The backlog holds up to PEND_LIMIT (8) obligations. An obligation that accrues in the same cycle as a granted start leaves the count unchanged and raises no overflow. An obligation that accrues while PEND_LIMIT are already waiting, with no start in that cycle, sets `pend_overflow`, which then stays 1 until reset.
- R7: With `cbr_mode` = 1, `cas_n` goes low CSR cycles before `ras_n` falls and stays low for CHR cycles after `ras_n` falls. `we_n` is 1 throughout.
- R8: In every refresh cycle `ras_n` is low for exactly RASLO cycles. Between two low periods `ras_n` is high for at least RP cycles.
- R9: With `cbr_mode` = 0, `cas_n` stays 1. `row_addr` is unchanged in the cycle before `ras_n` falls and stays constant while `ras_n` is low.
- R10: The row counter advances by one after each row-strobe-only cycle and wraps from all ones to 0. CAS-before-RAS cycles leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_MHZ MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| cbr_mode | input | 1 | 1: CAS-before-RAS refresh, 0: row-strobe-only refresh with internal row |
| grant | input | 1 | Controller hands the DRAM bus to this block |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| row_addr | output | ROW_W | Row presented in row-strobe-only refresh |
| ref_req | output | 1 | Request for the bus to run a refresh |
| init_done | output | 1 | Pause and warm-up burst complete |
| pend_overflow | output | 1 | Sticky: an obligation was lost to a full backlog |

## Verification
The backlog can be incremented by the interval timer and decremented by a granted start in the same clock edge. The bench holds `grant` low until the backlog is full, then raises it one cycle before a timer expiry, so that the start and the expiry coincide. It judges the result by `pend_overflow` staying 0 at that edge and by the strobes starting. It then rises exactly one interval later, when grant is held low again and the next expiry arrives on a full backlog.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {CG_IDLE, CG_SETUP, CG_RASLO, CG_PRECH} cg_state_e;
  typedef enum logic [1:0] {PH_PAUSE, PH_INIT, PH_RUN} phase_e;

  // Whole cycles covering a duration in ns at a clock in MHz, rounded up.
  function automatic int ns_to_cyc(int ns, int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Backlog count after one cycle of accrual and/or removal, saturating.
  function automatic int pend_step(int cur, bit inc, bit dec, int lim);
    int nxt;
    nxt = cur;
    if (inc && !dec && cur < lim) nxt = cur + 1;
    else if (dec && !inc && cur > 0) nxt = cur - 1;
    return nxt;
  endfunction

  // True when an accrual finds the backlog already full.
  function automatic bit pend_spill(int cur, bit inc, bit dec, int lim);
    return inc && !dec && (cur >= lim);
  endfunction

endpackage

// File: rtl/rfsh_phase_ctl.sv
module rfsh_phase_ctl
  import rfsh_pkg::*;
#(
  parameter int PAUSE_CYC = 25000,
  parameter int INIT_CYC  = 8,
  parameter int IVL_CYC   = 1950
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cyc_done,
  output phase_e phase,
  output logic   tick
);
  localparam int PW = $clog2(PAUSE_CYC + 1);
  localparam int IW = $clog2(IVL_CYC + 1);
  localparam int NW = $clog2(INIT_CYC + 1);

  logic [PW-1:0] pcnt;
  logic [IW-1:0] ivl;
  logic [NW-1:0] icnt;
  logic pause_end, init_end;

  assign pause_end = (phase == PH_PAUSE) && (pcnt == PW'(PAUSE_CYC - 1));
  assign init_end  = (phase == PH_INIT) && cyc_done && (icnt == NW'(INIT_CYC - 1));
  assign tick      = (phase == PH_RUN) && (ivl == IW'(IVL_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_PAUSE;
      pcnt  <= '0;
      ivl   <= '0;
      icnt  <= '0;
    end else begin
      case (phase)
        PH_PAUSE: begin
          pcnt <= pcnt + 1'b1;
          if (pause_end) phase <= PH_INIT;
        end
        PH_INIT: begin
          if (cyc_done) icnt <= icnt + 1'b1;
          if (init_end) begin
            phase <= PH_RUN;
            ivl   <= '0;
          end
        end
        default: ivl <= tick ? '0 : ivl + 1'b1;
      endcase
    end
  end

  p_run_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_RUN |=> phase == PH_RUN);

  p_tick_spaced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (IVL_CYC > 1) |=> !tick);

endmodule

// File: rtl/rfsh_pend.sv
module rfsh_pend
  import rfsh_pkg::*;
#(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic nonzero,
  output logic overflow
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      overflow <= 1'b0;
    end else begin
      cnt <= CW'(pend_step(int'(cnt), inc, dec, LIMIT));
      if (pend_spill(int'(cnt), inc, dec, LIMIT)) overflow <= 1'b1;
    end
  end

  assign nonzero = (cnt != '0);

  p_accrue_take_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inc && dec |=> $stable(cnt));

  p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_spill_when_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(cnt) == CW'(LIMIT));

endmodule

// File: rtl/rfsh_cycle_gen.sv
module rfsh_cycle_gen
  import rfsh_pkg::*;
#(
  parameter int CSR_CYC   = 2,
  parameter int CHR_CYC   = 1,
  parameter int ASR_CYC   = 1,
  parameter int RASLO_CYC = 8,
  parameter int RP_CYC    = 4,
  parameter int ROW_W     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode_cbr,
  output logic             ras_n,
  output logic             cas_n,
  output logic             idle,
  output logic             cyc_done,
  output logic [ROW_W-1:0] row
);
  localparam int LONGEST = imax(imax(CSR_CYC, ASR_CYC), imax(RASLO_CYC, RP_CYC));
  localparam int CW = $clog2(LONGEST + 1);
  localparam logic [CW-1:0] CSR_END = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] ASR_END = CW'(ASR_CYC - 1);
  localparam logic [CW-1:0] LO_END  = CW'(RASLO_CYC - 1);
  localparam logic [CW-1:0] RP_END  = CW'(RP_CYC - 1);
  localparam logic [CW-1:0] CHR_LEN = CW'(CHR_CYC);

  cg_state_e     state;
  logic [CW-1:0] cnt;
  logic          mode_q;
  logic          setup_end, cas_low;

  assign setup_end = (state == CG_SETUP) && (cnt == (mode_q ? CSR_END : ASR_END));
  assign cyc_done  = (state == CG_PRECH) && (cnt == RP_END);
  assign idle      = (state == CG_IDLE);
  assign cas_low   = mode_q && ((state == CG_SETUP) ||
                                ((state == CG_RASLO) && (cnt < CHR_LEN)));
  assign ras_n     = (state != CG_RASLO);
  assign cas_n     = !cas_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= CG_IDLE;
      cnt    <= '0;
      mode_q <= 1'b1;
      row    <= '0;
    end else begin
      case (state)
        CG_IDLE: if (start) begin
          state  <= CG_SETUP;
          cnt    <= '0;
          mode_q <= mode_cbr;
        end
        CG_SETUP: begin
          cnt <= setup_end ? '0 : cnt + 1'b1;
          if (setup_end) state <= CG_RASLO;
        end
        CG_RASLO: begin
          cnt <= (cnt == LO_END) ? '0 : cnt + 1'b1;
          if (cnt == LO_END) state <= CG_PRECH;
        end
        default: begin
          cnt <= cyc_done ? '0 : cnt + 1'b1;
          if (cyc_done) state <= CG_IDLE;
        end
      endcase
      if (cyc_done && !mode_q) row <= row + 1'b1;
    end
  end

  // Independent run-length counter feeding the width check.
  logic [CW:0] lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_run <= '0;
    else        lo_run <= ras_n ? '0 : lo_run + 1'b1;
  end

  p_ras_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> lo_run == (CW+1)'(RASLO_CYC));

  p_cas_leads_ras_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) && mode_q |-> !cas_n && $past(!cas_n));

  p_row_setup_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) && !mode_q |-> $stable(row) && cas_n);

  p_row_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    row != $past(row) |-> row == ROW_W'($past(row) + 1'b1));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import rfsh_pkg::*;
#(
  parameter int CLK_MHZ     = 125,
  parameter int PAUSE_NS    = 200000,
  parameter int INTERVAL_NS = 15600,
  parameter int INIT_CYCLES = 8,
  parameter int PEND_LIMIT  = 8,
  parameter int ROW_W       = 12,
  parameter int CSR_NS      = 10,
  parameter int CHR_NS      = 8,
  parameter int ASR_NS      = 5,
  parameter int RAS_LOW_NS  = 60,
  parameter int RP_NS       = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cbr_mode,
  input  logic             grant,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row_addr,
  output logic             ref_req,
  output logic             init_done,
  output logic             pend_overflow
);
  localparam int PAUSE_CYC = ns_to_cyc(PAUSE_NS, CLK_MHZ);
  localparam int IVL_CYC   = ns_to_cyc(INTERVAL_NS, CLK_MHZ);
  localparam int CSR_CYC   = ns_to_cyc(CSR_NS, CLK_MHZ);
  localparam int CHR_CYC   = ns_to_cyc(CHR_NS, CLK_MHZ);
  localparam int ASR_CYC   = ns_to_cyc(ASR_NS, CLK_MHZ);
  localparam int RASLO_CYC = ns_to_cyc(RAS_LOW_NS, CLK_MHZ);
  localparam int RP_CYC    = ns_to_cyc(RP_NS, CLK_MHZ);

  phase_e phase;
  logic   tick, cyc_done, gen_idle, pend_nz;
  logic   init_start, granted_start, start;

  rfsh_phase_ctl #(
    .PAUSE_CYC(PAUSE_CYC), .INIT_CYC(INIT_CYCLES), .IVL_CYC(IVL_CYC)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .cyc_done(cyc_done), .phase(phase), .tick(tick)
  );

  rfsh_pend #(.LIMIT(PEND_LIMIT)) u_pend (
    .clk(clk), .rst_n(rst_n), .inc(tick), .dec(granted_start),
    .nonzero(pend_nz), .overflow(pend_overflow)
  );

  rfsh_cycle_gen #(
    .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC), .ASR_CYC(ASR_CYC),
    .RASLO_CYC(RASLO_CYC), .RP_CYC(RP_CYC), .ROW_W(ROW_W)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_cbr(cbr_mode),
    .ras_n(ras_n), .cas_n(cas_n), .idle(gen_idle), .cyc_done(cyc_done),
    .row(row_addr)
  );

  assign init_done     = (phase == PH_RUN);
  assign init_start    = (phase == PH_INIT) && gen_idle;
  assign ref_req       = init_done && pend_nz && gen_idle;
  assign granted_start = ref_req && grant;
  assign start         = init_start || granted_start;
  assign we_n          = 1'b1;

  p_quiet_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_PAUSE |-> ras_n && cas_n);

  p_no_req_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !ref_req);

  p_grant_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req && grant |=> !ref_req && !gen_idle);

  p_row_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n && $past(!ras_n) |-> $stable(row_addr));

endmodule

// File: tb/tb_dram_refresh_seq.sv
`timescale 1ns/1ps
module tb_dram_refresh_seq;

  function automatic int cyc_of(int ns);
    int c;
    c = 0;
    while (c * 8 < ns) c++;
    return c;
  endfunction

  localparam int RW  = 4;
  localparam int P   = cyc_of(160);
  localparam int IV  = cyc_of(320);
  localparam int CSR = cyc_of(10);
  localparam int CHR = cyc_of(8);
  localparam int LO  = cyc_of(60);
  localparam int RP  = cyc_of(30);
  localparam int NINIT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cbr_mode = 1'b1;
  logic grant = 1'b0;
  logic ras_n, cas_n, we_n, ref_req, init_done, pend_overflow;
  logic [RW-1:0] row_addr;

  always #4 clk = ~clk;

  dram_refresh_seq #(
    .CLK_MHZ(125), .PAUSE_NS(160), .INTERVAL_NS(320), .INIT_CYCLES(NINIT),
    .PEND_LIMIT(8), .ROW_W(RW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cbr_mode(cbr_mode), .grant(grant),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .row_addr(row_addr),
    .ref_req(ref_req), .init_done(init_done), .pend_overflow(pend_overflow)
  );

  int n_cmp = 0, n_bad = 0;
  int mon_cmp = 0, mon_bad = 0;
  int edges = 0;

  always @(posedge clk) edges <= rst_n ? edges + 1 : 0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic mchk(bit ok, string tag, int act, int exp);
    mon_cmp++;
    if (!ok) begin
      mon_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Strobe monitor, sampling on the falling edge.
  int  falls, first_act, rise_edge, ras_run, hi_run, cas_run, cas_in_lo;
  int  exp_row, row_fall, last_fall_row;
  bit  prev_ras, row_moved, req_in_init, wrap_seen;
  logic [RW-1:0] prev_row;

  always @(negedge clk) begin
    if (!rst_n) begin
      falls = 0; first_act = -1; rise_edge = 0; ras_run = 0; hi_run = 0;
      cas_run = 0; cas_in_lo = 0; exp_row = 0; row_fall = 0; last_fall_row = -1;
      prev_ras = 1'b1; row_moved = 1'b0; req_in_init = 1'b0; wrap_seen = 1'b0;
      prev_row = '0;
    end else begin
      if (first_act < 0 && (!ras_n || !cas_n)) first_act = edges;
      if (!init_done && ref_req) req_in_init = 1'b1;
      if (prev_ras && !ras_n) begin
        falls++;
        mchk(we_n == 1'b1, "R7 we_n high at ras fall", we_n, 1);
        mchk(hi_run >= RP, "R8 ras high gap", hi_run, RP);
        mchk(int'(row_addr) == exp_row, "R10 row at ras fall", row_addr, exp_row);
        if (cbr_mode) begin
          mchk(cas_run == CSR, "R7 cas lead before ras fall", cas_run, CSR);
        end else begin
          mchk(cas_n == 1'b1, "R9 cas high in row-only", cas_n, 1);
          mchk(row_addr == prev_row, "R9 row setup before ras fall", row_addr, prev_row);
          if (row_addr == '0 && last_fall_row == (1 << RW) - 1) wrap_seen = 1'b1;
        end
        last_fall_row = row_addr;
        row_fall = row_addr;
        row_moved = 1'b0;
        cas_in_lo = 0;
      end
      if (!ras_n) begin
        if (int'(row_addr) != row_fall) row_moved = 1'b1;
        if (!cas_n) cas_in_lo++;
      end
      if (!prev_ras && ras_n) begin
        rise_edge = edges;
        mchk(ras_run == LO, "R8 ras low width", ras_run, LO);
        if (cbr_mode) begin
          mchk(cas_in_lo == CHR, "R7 cas hold after ras fall", cas_in_lo, CHR);
        end else begin
          mchk(cas_in_lo == 0, "R9 cas stays high", cas_in_lo, 0);
          mchk(!row_moved, "R9 row stable while ras low", row_moved, 0);
          exp_row = (exp_row + 1) % (1 << RW);
        end
      end
      ras_run = ras_n ? 0 : ras_run + 1;
      hi_run  = ras_n ? hi_run + 1 : 0;
      cas_run = cas_n ? 0 : cas_run + 1;
      prev_ras = ras_n;
      prev_row = row_addr;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             n_cmp + mon_cmp, n_bad + mon_bad);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  task automatic wait_init();
    while (!init_done) @(negedge clk);
  endtask

  initial begin
    int base;
    // ---------------- CAS-before-RAS run ----------------
    cbr_mode = 1'b1; grant = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(ras_n == 1'b1, "R1 reset ras_n", ras_n, 1);
    check(cas_n == 1'b1, "R1 reset cas_n", cas_n, 1);
    check(we_n == 1'b1, "R1 reset we_n", we_n, 1);
    check(ref_req == 1'b0, "R1 reset ref_req", ref_req, 0);
    check(init_done == 1'b0, "R1 reset init_done", init_done, 0);
    check(pend_overflow == 1'b0, "R1 reset overflow", pend_overflow, 0);
    check(row_addr == '0, "R1 reset row", row_addr, 0);
    rst_n = 1'b1;
    wait_init();
    check(first_act == P + 1, "R2 first strobe after pause", first_act, P + 1);
    check(falls == NINIT, "R3 warm-up cycles without grant", falls, NINIT);
    check(edges - rise_edge == RP, "R3 init_done after last precharge",
          edges - rise_edge, RP);
    check(!req_in_init, "R3 no request during init", req_in_init, 0);
    // offset 0 is now; each loop step is one clock
    for (int off = 1; off <= 9 * IV; off++) begin
      @(negedge clk);
      if (off == IV - 1) check(ref_req == 1'b0, "R4 no request before interval", ref_req, 0);
      if (off == IV) check(ref_req == 1'b1, "R4 request after one interval", ref_req, 1);
      if (off == 9 * IV - 1) begin
        check(pend_overflow == 1'b0, "R6 no overflow with full backlog", pend_overflow, 0);
        check(ref_req == 1'b1, "R5 request while backlog pending", ref_req, 1);
        grant = 1'b1;
      end
      if (off == 9 * IV) begin
        check(pend_overflow == 1'b0, "R6 accrual with start: no overflow", pend_overflow, 0);
        check(cas_n == 1'b0, "R5 refresh started on grant", cas_n, 0);
        check(ref_req == 1'b0, "R5 request drops once started", ref_req, 0);
        grant = 1'b0;
      end
    end
    for (int off = 9 * IV + 1; off <= 10 * IV; off++) begin
      @(negedge clk);
      if (off == 10 * IV - 1) check(pend_overflow == 1'b0, "R6 overflow not early", pend_overflow, 0);
      if (off == 10 * IV) check(pend_overflow == 1'b1, "R6 overflow on full accrual", pend_overflow, 1);
    end
    grant = 1'b1;
    repeat (20 * IV) @(negedge clk);
    check(pend_overflow == 1'b1, "R6 overflow sticky", pend_overflow, 1);
    while (!(prev_ras == 1'b0 && ras_run == 1)) @(negedge clk);
    base = falls;
    repeat (10 * IV) @(negedge clk);
    check(falls - base == 10, "R4 one refresh per interval", falls - base, 10);
    check(row_addr == '0, "R10 row unchanged by CBR cycles", row_addr, 0);

    // ---------------- row-strobe-only run ----------------
    @(negedge clk);
    rst_n = 1'b0; cbr_mode = 1'b0; grant = 1'b1;
    repeat (3) @(negedge clk);
    check(row_addr == '0 && ras_n == 1'b1, "R1 reset again", row_addr, 0);
    rst_n = 1'b1;
    wait_init();
    check(falls == NINIT, "R3 warm-up count with grant high", falls, NINIT);
    check(!req_in_init, "R3 grant ignored during init", req_in_init, 0);
    check(first_act == P + 1 + 1, "R2 row-only first strobe after setup",
          first_act, P + 2);
    repeat (15 * IV) @(negedge clk);
    check(wrap_seen, "R10 row counter wraps to 0", wrap_seen, 1);
    check(falls >= NINIT + 14, "R4 refreshes in run", falls, NINIT + 14);
    summary();
    $finish;
  end

endmodule